// File: doc/BRIEF.md
# Sequential Booth multiplier

This block multiplies two signed two's-complement operands of `W` bits over several clock cycles and returns the signed product of `2W` bits. A single-cycle `start` pulse, accepted only while the block is idle, captures both operands. For each multiplier bit, the block inspects the current low bit of the multiplier register together with the bit that was shifted out of it in the previous step.

At the boundaries of runs of equal multiplier bits, the block either adds the multiplicand into an accumulator or subtracts it. Inside a run it does neither. In every step, after that arithmetic, the whole accumulator:multiplier:extra-bit chain shifts right by one place, and the sign bit is copied into the vacated position.

The accumulator is one bit wider than the operands. This lets the subtraction of the most negative multiplicand stay exact. When the step counter runs out, `done` rises and stays high, and the product is held stable until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 makes `busy` 1 and `done` 0 in the next cycle. `done` and `busy` are never 1 together.
- R3: `busy` stays high for exactly `W` cycles. `done` rises on the `W`-th clock edge after the edge that accepted `start`.
- R4: When `done` rises, `product` equals the signed product of `multiplicand` and `multiplier`, as both were sampled at the accepted start, taken modulo 2^(2W). This covers positive, negative and zero operands.
- R5: Multiplying the most negative value (only bit W-1 set) by itself gives 2^(2W-2), which is exact in 2W bits.
- R6: A `start` that arrives while `busy` is 1 is ignored. The operand values present then have no effect, and completion timing is unchanged.
- R7: Once `done` is 1 and no new start is accepted, `done` stays 1 and `product` holds its value, whatever the operand inputs do.
- R8: In steps where the inspected bit pair is equal (00 or 11), the accumulator changes only by the arithmetic shift. Pair 10 (current 1, previous 0) subtracts the multiplicand and pair 01 adds it. As a result, an all-zeros multiplier gives 0 and an all-ones multiplier gives the negated multiplicand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | W | Signed multiplicand, sampled at accepted start |
| multiplier | input | W | Signed multiplier, sampled at accepted start |
| product | output | 2W | Signed product, valid while `done` is 1 |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | High from completion until the next accepted start |

## Verification
On every cycle, the checker watches four things:
- the handshake between `start`, `busy` and `done`;
- the exact length of the busy window, measured by its own counter;
- the stability of a finished result;
- that a step with an equal bit pair leaves the accumulator changed only by the shift.

The numerical correctness of the product, including the most-negative-squared case and the all-zeros and all-ones multipliers, is shown only by the bench. The same holds for the claim that a start issued mid-run disturbs neither timing nor result. The bench compares against products it computes itself.

// File: rtl/booth_pkg.sv
package booth_pkg;

   // Arithmetic action chosen by radix-2 recoding of one bit pair
   typedef enum logic [1:0] {
      BOOTH_HOLD = 2'd0,
      BOOTH_ADD  = 2'd1,
      BOOTH_SUB  = 2'd2
   } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic      cur_bit,
   input  logic      prev_bit,
   output booth_op_e op
);

   // 10: start of a run of ones -> subtract; 01: end of run -> add
   always_comb begin
      unique case ({cur_bit, prev_bit})
         2'b10:   op = BOOTH_SUB;
         2'b01:   op = BOOTH_ADD;
         default: op = BOOTH_HOLD;
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int AW          = 9,
   parameter bit SUB_BY_INV  = 1'b1
)(
   input  logic [AW-1:0] acc,
   input  logic [AW-1:0] addend,
   input  booth_op_e     op,
   output logic [AW-1:0] sum
);

   generate
      if (SUB_BY_INV) begin : g_inv
         // Single adder: operand muxed between addend and its inverse, carry-in supplies +1
         logic [AW-1:0] opnd;
         logic          cin;
         always_comb begin
            opnd = '0;
            cin  = 1'b0;
            if (op == BOOTH_ADD) begin
               opnd = addend;
            end else if (op == BOOTH_SUB) begin
               opnd = ~addend;
               cin  = 1'b1;
            end
         end
         assign sum = acc + opnd + AW'(cin);
      end else begin : g_direct
         always_comb begin
            unique case (op)
               BOOTH_ADD: sum = acc + addend;
               BOOTH_SUB: sum = acc - addend;
               default:   sum = acc;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/booth_shift.sv
module booth_shift #(
   parameter int W = 8
)(
   input  logic [W:0]   sum_in,
   input  logic [W-1:0] qr_in,
   output logic [W:0]   acc_out,
   output logic [W-1:0] qr_out,
   output logic         qx_out
);

   // Arithmetic right shift of the acc:qr:qx chain by one place
   assign acc_out = {sum_in[W], sum_in[W:1]};
   assign qr_out  = {sum_in[0], qr_in[W-1:1]};
   assign qx_out  = qr_in[0];

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int W  = 8,
   parameter int CW = $clog2(W + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);

   logic [CW-1:0] cnt_q;

   assign load = start && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else if (load) begin
         cnt_q <= CW'(W);
         busy  <= 1'b1;
         done  <= 1'b0;
      end else if (busy) begin
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import booth_pkg::*;
#(
   parameter int W          = 8,
   parameter bit SUB_BY_INV = 1'b1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   multiplicand,
   input  logic [W-1:0]   multiplier,
   output logic [2*W-1:0] product,
   output logic           busy,
   output logic           done
);

   localparam int AW = W + 1;   // one guard bit keeps -(most negative) exact
   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("booth_seq_mult: W must be at least 2");
      end
   endgenerate

   logic [AW-1:0] acc_q, acc_n, sum;
   logic [W-1:0]  qr_q, qr_n, mcand_q;
   logic          qx_q, qx_n;
   logic          load, step;
   booth_op_e     op;

   booth_seq_ctrl #(.W(W), .CW(CW)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   booth_recode u_recode (
      .cur_bit  (qr_q[0]),
      .prev_bit (qx_q),
      .op       (op)
   );

   booth_addsub #(.AW(AW), .SUB_BY_INV(SUB_BY_INV)) u_addsub (
      .acc    (acc_q),
      .addend ({mcand_q[W-1], mcand_q}),
      .op     (op),
      .sum    (sum)
   );

   booth_shift #(.W(W)) u_shift (
      .sum_in  (sum),
      .qr_in   (qr_q),
      .acc_out (acc_n),
      .qr_out  (qr_n),
      .qx_out  (qx_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         qr_q    <= '0;
         qx_q    <= 1'b0;
         mcand_q <= '0;
      end else if (load) begin
         acc_q   <= '0;
         qr_q    <= multiplier;
         qx_q    <= 1'b0;
         mcand_q <= multiplicand;
      end else if (step) begin
         acc_q   <= acc_n;
         qr_q    <= qr_n;
         qx_q    <= qx_n;
      end
   end

   assign product = {acc_q[W-1:0], qr_q};

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
   parameter int W = 8
)(
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic [2*W-1:0] product,
   input logic [W:0]     acc,
   input logic           qr0,
   input logic           qx
);

   localparam int CW = $clog2(W + 2);

   logic [CW-1:0] busy_cyc;

   // Count busy cycles since the accepted start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy_cyc <= '0;
      else if (start && !busy)   busy_cyc <= '0;
      else if (busy)             busy_cyc <= busy_cyc + CW'(1);
   end

   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));

   p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cyc == CW'(W)));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(product)));

   p_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (qr0 == qx)) |=> (acc == {$past(acc[W]), $past(acc[W:1])}));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .product (product),
   .acc     (acc_q),
   .qr0     (qr_q[0]),
   .qx      (qx_q)
);

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;

   localparam int  W        = 8;
   localparam time CLK_PER  = 10ns;
   localparam int  WATCHDOG = 20000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic [2*W-1:0] product;
   logic           busy, done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   booth_seq_mult #(.W(W)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .multiplicand (mcand),
      .multiplier   (mplier),
      .product      (product),
      .busy         (busy),
      .done         (done)
   );

   always #(CLK_PER/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog: actual cycle %0d expected < %0d", cyc, WATCHDOG);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] ea, eb;
      ea = {{W{a[W-1]}}, a};
      eb = {{W{b[W-1]}}, b};
      return ea * eb;
   endfunction

   task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One multiplication with exact timing checks; inject_mid issues a stray start mid-run
   task automatic run_mul(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit inject_mid);
      @(negedge clk);
      mcand = a; mplier = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " R2 busy after start"}, {15'd0, busy}, 16'd1);
      check({req, " R2 done cleared"},     {15'd0, done}, 16'd0);
      for (int k = 1; k < W; k++) begin
         if (inject_mid && k == 3) begin
            mcand = ~a; mplier = a ^ b ^ 8'h5A; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      check({req, " R3 not done one early"}, {14'd0, busy, done}, 16'b10);
      @(negedge clk);
      check({req, " R3 done on W-th step"}, {14'd0, busy, done}, 16'b01);
      check({req, " R4 product"}, product, ref_mul(a, b));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 product at reset", product, '0);
      check("R1 busy/done at reset", {14'd0, busy, done}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_signs();
      run_mul("R4 pos*pos", 8'd14, 8'd11, 0);
      run_mul("R4 neg*pos", 8'hF3, 8'd27, 0);
      run_mul("R4 pos*neg", 8'd100, 8'h9C, 0);
      run_mul("R4 neg*neg", 8'h81, 8'hC0, 0);
      run_mul("R4 zero cand", 8'd0, 8'h77, 0);
      run_mul("R4 max*max", 8'h7F, 8'h7F, 0);
   endtask

   task automatic t_most_negative();
      run_mul("R5 minneg squared", 8'h80, 8'h80, 0);
      check("R5 value 2^(2W-2)", product, 16'h4000);
      run_mul("R5 minneg*max", 8'h80, 8'h7F, 0);
   endtask

   task automatic t_runs();
      run_mul("R8 mult all zeros", 8'h35, 8'h00, 0);
      check("R8 zero result", product, 16'h0000);
      run_mul("R8 mult all ones", 8'h35, 8'hFF, 0);
      check("R8 negated cand", product, 16'hFFCB);
      run_mul("R8 alternating", 8'hD9, 8'h55, 0);
      run_mul("R8 run 001110", 8'd9, 8'b0000_1110, 0);
   endtask

   task automatic t_start_while_busy();
      run_mul("R6 stray start", 8'h2B, 8'hE7, 1);
   endtask

   task automatic t_hold();
      logic [2*W-1:0] held;
      run_mul("R7 setup", 8'h3C, 8'hA5, 0);
      held = product;
      for (int k = 0; k < 6; k++) begin
         mcand = 8'(k * 37); mplier = 8'(k * 91 + 3);
         @(negedge clk);
      end
      check("R7 product held", product, held);
      check("R7 done held", {15'd0, done}, 16'd1);
   endtask

   task automatic t_sweep();
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         run_mul("R4 sweep", lfsr[7:0], lfsr[15:8], 0);
      end
   endtask

   initial begin
      t_reset();
      t_signs();
      t_most_negative();
      t_runs();
      t_start_while_busy();
      t_hold();
      t_sweep();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule